// File: doc/BRIEF.md
# Bidirectional Ring Transfer Arbiter

This block decides which ring stop may start a transfer, and on which ring, in an interconnect where twelve stops sit on four 16-byte rings. Rings 0 and 1 carry data clockwise and rings 2 and 3 carry it counterclockwise. The clockwise order runs from stop 0 up to stop 11 and then wraps back to stop 0. A stop raises a level request with a destination index. The arbiter works out the shorter way round and the hop segments that path uses. It grants the request on the first ring of that direction where none of those segments is taken and fewer than three transfers are in flight. The segments stay reserved until the source stop pulses its done line.

More than one transfer can share a ring as long as their segments are disjoint. Each ring holds at most three transfers at once, and each active transfer moves one 16-byte beat per cycle on its own datapath, which lies outside this block. The arbiter gives at most one grant per cycle and picks among the eligible stops with a rotating priority pointer. A stop whose request cannot be placed keeps waiting in its own direction.

Top module: `ring_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `grant_o`, `err_o`, every `ring_o` entry and every `busy_o` segment bit are zero.
- R2: Let h = (dst - src) mod 12. A request goes clockwise (ring 0 or 1) when h <= 6, including the tie at h = 6. Otherwise it goes counterclockwise (ring 2 or 3). `ring_o[src]` holds the assigned ring index from the cycle after the grant until release.
- R3: Segment k joins stop k and stop k+1 mod 12 and appears as bit k of `busy_o[ring]`. A clockwise transfer reserves bits src, src+1, ..., src+h-1 mod 12. A counterclockwise transfer reserves bits dst, dst+1, ..., src-1 mod 12.
- R4: A request is granted on a ring only when none of its segments is set in that ring's busy map. When both rings of its direction fit, the lower-numbered ring is taken.
- R5: No ring ever carries more than three active transfers. A fourth request that fits no ring of its direction is not granted.
- R6: A request that fits neither ring of its direction stays pending with no grant and never takes the other direction. It is granted on the first cycle after a blocking transfer has been released.
- R7: At most one stop is granted per cycle. `grant_o` is a one-cycle pulse appearing the cycle after the request is seen. Among eligible stops, the first one found searching upward from the stop after the last winner is chosen.
- R8: A request whose destination equals its source, or whose destination is 12 or above, gets an `err_o` pulse for that stop in the next cycle. It is never granted and reserves no segment.
- R9: A `done_i` pulse from a stop with an active transfer clears that transfer's segments from `busy_o` by the next cycle. A `done_i` from an idle stop has no effect.
- R10: While a stop's transfer is active, its request line is ignored: it gets no further grant and the busy maps stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 12 | Per-stop level request |
| dst_i | input | 12x4 | Per-stop destination stop index |
| done_i | input | 12 | Per-stop end-of-transfer pulse |
| grant_o | output | 12 | Per-stop one-cycle grant pulse |
| err_o | output | 12 | Per-stop invalid-request pulse |
| ring_o | output | 12x2 | Per-stop assigned ring index |
| busy_o | output | 4x12 | Per-ring hop-segment reservation map |

## Verification
The bench targets the half-way tie at six hops. A design that breaks the tie the wrong way puts the transfer on ring 2 instead of ring 0. It checks a counterclockwise path that wraps past stop 0, where an off-by-one in the segment arithmetic shows up as a shifted busy map. It blocks a short request on both clockwise rings while the counterclockwise rings sit idle. A design that spills into the longer direction, or that grants before the blocker releases, is caught by the exact grant cycle. Four disjoint transfers are also aimed at one ring, and a fifth stop is checked against the priority pointer, exposing a missing cap or a fixed-priority search.

// File: rtl/ring_arb_pkg.sv
// Shared definitions for the ring transfer arbiter.
// Assumes: a single clock domain; stop indices count clockwise.
package ring_arb_pkg;
    typedef enum logic {
        DIR_CW  = 1'b0,
        DIR_CCW = 1'b1
    } ring_dir_e;

    localparam int RA_NSTOP = 12;   // stops on the ring
    localparam int RA_NRING = 4;    // rings, half per direction
    localparam int RA_MAXX  = 3;    // transfers one ring may carry
endpackage

// File: rtl/ring_arb_path.sv
// Path computation for one source stop: picks the shorter direction,
// with the tie going clockwise, and builds the hop-segment mask.
// Segment k joins stop k and stop k+1 (mod NSTOP).
// Assumes: SRC < NSTOP; a destination >= NSTOP is reported as bad.
module ring_arb_path
    import ring_arb_pkg::*;
#(
    parameter int NSTOP = RA_NSTOP,
    parameter int SRC   = 0,
    localparam int IDX_W = $clog2(NSTOP)
) (
    input  logic [IDX_W-1:0] dst_i,
    output logic [NSTOP-1:0] mask_o,
    output ring_dir_e        dir_o,
    output logic             bad_o
);
    localparam int HALF = NSTOP / 2;

    // Hop count, direction and segment mask for this source.
    always_comb begin
        int d;
        int hcw;
        int hccw;
        d      = int'(dst_i);
        bad_o  = (d >= NSTOP) || (d == SRC);
        hcw    = (d - SRC + NSTOP) % NSTOP;
        hccw   = (NSTOP - hcw) % NSTOP;
        dir_o  = (hcw <= HALF) ? DIR_CW : DIR_CCW;
        mask_o = '0;
        for (int k = 0; k < NSTOP; k++) begin
            if (dir_o == DIR_CW) begin
                mask_o[k] = ((k - SRC + NSTOP) % NSTOP) < hcw;
            end else begin
                mask_o[k] = ((SRC - 1 - k + 2 * NSTOP) % NSTOP) < hccw;
            end
        end
        if (bad_o) begin
            mask_o = '0;
        end
    end
endmodule

// File: rtl/ring_arb_rr.sv
// Rotating-priority picker: returns the first set eligibility bit found
// searching upward (with wrap) from the pointer position.
// Assumes: ptr_i < N.
module ring_arb_rr #(
    parameter int N = 12,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig_i,
    input  logic [IW-1:0] ptr_i,
    output logic          found_o,
    output logic [IW-1:0] win_o
);
    // Scan from farthest to nearest so the nearest eligible stop wins.
    always_comb begin
        int idx;
        found_o = 1'b0;
        win_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = (int'(ptr_i) + k) % N;
            if (elig_i[idx]) begin
                found_o = 1'b1;
                win_o   = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/ring_arb_table.sv
// Active-transfer table: one slot per source stop holding its ring and
// segment mask; derives each ring's busy map and transfer count.
// Assumes: install never targets a stop whose slot is active.
module ring_arb_table
    import ring_arb_pkg::*;
#(
    parameter int NSTOP = RA_NSTOP,
    parameter int NRING = RA_NRING,
    parameter int MAXX  = RA_MAXX,
    localparam int IDX_W = $clog2(NSTOP),
    localparam int RW    = $clog2(NRING),
    localparam int CW    = $clog2(MAXX + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        install_v,
    input  logic [IDX_W-1:0]            install_stop,
    input  logic [RW-1:0]               install_ring,
    input  logic [NSTOP-1:0]            install_mask,
    input  logic [NSTOP-1:0]            done_i,
    output logic [NSTOP-1:0]            active_o,
    output logic [NSTOP-1:0][RW-1:0]    ring_o,
    output logic [NRING-1:0][NSTOP-1:0] busy_o,
    output logic [NRING-1:0][CW-1:0]    cnt_o
);
    logic [NSTOP-1:0]             active_q;
    logic [NSTOP-1:0][RW-1:0]     ring_q;
    logic [NSTOP-1:0][NSTOP-1:0]  mask_q;

    // Slot update: release on done, fill on install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            ring_q   <= '0;
            mask_q   <= '0;
        end else begin
            for (int i = 0; i < NSTOP; i++) begin
                if (done_i[i] && active_q[i]) begin
                    active_q[i] <= 1'b0;
                    ring_q[i]   <= '0;
                    mask_q[i]   <= '0;
                end
                if (install_v && (install_stop == IDX_W'(i))) begin
                    active_q[i] <= 1'b1;
                    ring_q[i]   <= install_ring;
                    mask_q[i]   <= install_mask;
                end
            end
        end
    end

    // Per-ring busy map and occupancy from the active slots.
    always_comb begin
        busy_o = '0;
        cnt_o  = '0;
        for (int r = 0; r < NRING; r++) begin
            for (int i = 0; i < NSTOP; i++) begin
                if (active_q[i] && (ring_q[i] == RW'(r))) begin
                    busy_o[r] = busy_o[r] | mask_q[i];
                    cnt_o[r]  = cnt_o[r] + CW'(1);
                end
            end
        end
    end

    assign active_o = active_q;
    assign ring_o   = ring_q;

    // A new transfer never lands on segments already held on its ring.
    p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        install_v |-> ((busy_o[install_ring] & install_mask) == '0));

    generate
        for (genvar r = 0; r < NRING; r++) begin : g_ring_chk
            // Ring occupancy stays within the per-ring limit.
            p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
                int'(cnt_o[r]) <= MAXX);
        end
        for (genvar i = 0; i < NSTOP; i++) begin : g_slot_chk
            // Done on an active slot frees it by the next cycle.
            p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (done_i[i] && active_q[i]) |=> !active_q[i]);
        end
    endgenerate
endmodule

// File: rtl/ring_arbiter.sv
// Top of the ring transfer arbiter. Per stop: computes the path, finds the
// lowest ring of the chosen direction with free segments and spare
// capacity, then one stop per cycle is granted by rotating priority.
// Assumes: requests are level signals held until granted; done_i is
// pulsed by the source stop at the end of its transfer.
module ring_arbiter
    import ring_arb_pkg::*;
#(
    parameter int NSTOP = RA_NSTOP,
    parameter int NRING = RA_NRING,
    parameter int MAXX  = RA_MAXX,
    localparam int IDX_W = $clog2(NSTOP),
    localparam int RW    = $clog2(NRING),
    localparam int CW    = $clog2(MAXX + 1),
    localparam int RPD   = NRING / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSTOP-1:0]            req_i,
    input  logic [NSTOP-1:0][IDX_W-1:0] dst_i,
    input  logic [NSTOP-1:0]            done_i,
    output logic [NSTOP-1:0]            grant_o,
    output logic [NSTOP-1:0]            err_o,
    output logic [NSTOP-1:0][RW-1:0]    ring_o,
    output logic [NRING-1:0][NSTOP-1:0] busy_o
);
    logic [NSTOP-1:0][NSTOP-1:0] path_mask;
    ring_dir_e [NSTOP-1:0]       path_dir;
    logic [NSTOP-1:0]            path_bad;
    logic [NSTOP-1:0]            fit_any;
    logic [NSTOP-1:0][RW-1:0]    fit_ring;
    logic [NSTOP-1:0]            active;
    logic [NRING-1:0][CW-1:0]    ring_cnt;
    logic [NSTOP-1:0]            elig;
    logic                        win_v;
    logic [IDX_W-1:0]            win_idx;
    logic [IDX_W-1:0]            ptr_q;
    logic [NSTOP-1:0]            grant_q;
    logic [NSTOP-1:0]            err_q;

    generate
        for (genvar i = 0; i < NSTOP; i++) begin : g_stop
            ring_arb_path #(.NSTOP(NSTOP), .SRC(i)) u_path (
                .dst_i  (dst_i[i]),
                .mask_o (path_mask[i]),
                .dir_o  (path_dir[i]),
                .bad_o  (path_bad[i])
            );

            // Lowest ring of the chosen direction that can take this path.
            always_comb begin
                int r;
                fit_any[i]  = 1'b0;
                fit_ring[i] = '0;
                for (int j = RPD - 1; j >= 0; j--) begin
                    r = (path_dir[i] == DIR_CCW) ? (RPD + j) : j;
                    if (((busy_o[r] & path_mask[i]) == '0) &&
                        (int'(ring_cnt[r]) < MAXX)) begin
                        fit_any[i]  = 1'b1;
                        fit_ring[i] = RW'(r);
                    end
                end
            end

            // A request may compete when idle, valid and placeable.
            assign elig[i] = req_i[i] && !active[i] && !path_bad[i] && fit_any[i];
        end
    endgenerate

    ring_arb_rr #(.N(NSTOP)) u_rr (
        .elig_i  (elig),
        .ptr_i   (ptr_q),
        .found_o (win_v),
        .win_o   (win_idx)
    );

    ring_arb_table #(.NSTOP(NSTOP), .NRING(NRING), .MAXX(MAXX)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .install_v    (win_v),
        .install_stop (win_idx),
        .install_ring (fit_ring[win_idx]),
        .install_mask (path_mask[win_idx]),
        .done_i       (done_i),
        .active_o     (active),
        .ring_o       (ring_o),
        .busy_o       (busy_o),
        .cnt_o        (ring_cnt)
    );

    // Grant and error pulses, and the rotating priority pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            err_q   <= '0;
            ptr_q   <= '0;
        end else begin
            grant_q <= '0;
            err_q   <= req_i & ~active & path_bad;
            if (win_v) begin
                grant_q[win_idx] <= 1'b1;
                ptr_q <= (win_idx == IDX_W'(NSTOP - 1)) ? '0 : win_idx + IDX_W'(1);
            end
        end
    end

    assign grant_o = grant_q;
    assign err_o   = err_q;

    // At most one grant per cycle.
    p_onegrant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // An invalid request is never granted.
    p_badnogrant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o & grant_o) == '0);

    // A granted stop owns an active slot from the grant cycle on.
    p_grantact_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~active) == '0);
endmodule

// File: tb/ring_arbiter_test.sv
module ring_arbiter_test;
    localparam int N  = 12;
    localparam int NR = 4;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [N-1:0]         req;
    logic [N-1:0][3:0]    dst;
    logic [N-1:0]         done;
    logic [N-1:0]         grant;
    logic [N-1:0]         err;
    logic [N-1:0][1:0]    ring;
    logic [NR-1:0][N-1:0] busy;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ring_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .dst_i(dst), .done_i(done),
        .grant_o(grant), .err_o(err), .ring_o(ring), .busy_o(busy)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic release_all();
        req  = '0;
        done = '1;
        step();
        done = '0;
        step();
    endtask

    task automatic t_reset();
        chk("R1 grant", 64'(grant), 0);
        chk("R1 err", 64'(err), 0);
        chk("R1 ring", 64'(ring), 0);
        chk("R1 busy", 64'(busy), 0);
    endtask

    task automatic t_cw_short();
        req[0] = 1'b1; dst[0] = 4'd3;
        step();
        chk("R7 grant pulse", 64'(grant), 64'h001);
        chk("R2 cw ring", 64'(ring[0]), 0);
        chk("R3 cw segs", 64'(busy[0]), 64'h007);
        step();
        chk("R10 no regrant", 64'(grant), 0);
        chk("R10 busy held", 64'(busy[0]), 64'h007);
        req = '0; done[0] = 1'b1;
        step();
        done = '0;
        chk("R9 released", 64'(busy[0]), 0);
        done[5] = 1'b1;
        step();
        done = '0;
        chk("R9 idle done", 64'(busy), 0);
    endtask

    task automatic t_tie_and_ccw();
        req[0] = 1'b1; dst[0] = 4'd6;
        step();
        chk("R2 tie cw", 64'(ring[0]), 0);
        chk("R3 tie segs", 64'(busy[0]), 64'h03F);
        release_all();
        req[0] = 1'b1; dst[0] = 4'd7;
        step();
        chk("R2 ccw ring", 64'(ring[0]), 2);
        chk("R3 ccw segs", 64'(busy[2]), 64'hF80);
        release_all();
        req[2] = 1'b1; dst[2] = 4'd10;
        step();
        chk("R2 ccw wrap ring", 64'(ring[2]), 2);
        chk("R3 ccw wrap segs", 64'(busy[2]), 64'hC03);
        release_all();
    endtask

    task automatic t_blocked();
        req[0] = 1'b1; dst[0] = 4'd3;
        step();
        req[0] = 1'b0;
        req[1] = 1'b1; dst[1] = 4'd4;
        step();
        req[1] = 1'b0;
        chk("R4 second ring", 64'(ring[1]), 1);
        chk("R4 second segs", 64'(busy[1]), 64'h00E);
        req[2] = 1'b1; dst[2] = 4'd3;
        step();
        chk("R6 pending", 64'(grant), 0);
        step();
        chk("R6 still pending", 64'(grant), 0);
        chk("R6 no ccw", 64'({busy[3], busy[2]}), 0);
        done[0] = 1'b1;
        step();
        done = '0;
        chk("R6 not early", 64'(grant), 0);
        step();
        chk("R6 late grant", 64'(grant), 64'h004);
        chk("R6 ring0", 64'(ring[2]), 0);
        release_all();
    endtask

    task automatic t_capacity();
        for (int s = 0; s < 8; s += 2) begin
            req[s] = 1'b1; dst[s] = 4'(s + 1);
        end
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R7 one per cycle", 64'($countones(grant)), 1);
        end
        chk("R5 ring0 full", 64'($countones(busy[0])), 3);
        chk("R5 overflow ring1", 64'($countones(busy[1])), 1);
        release_all();
    endtask

    task automatic t_round_robin();
        req[8] = 1'b1; dst[8] = 4'd9;
        step();
        chk("R7 solo", 64'(grant), 64'h100);
        release_all();
        req[2] = 1'b1; dst[2] = 4'd3;
        req[10] = 1'b1; dst[10] = 4'd11;
        step();
        chk("R7 rotate first", 64'(grant), 64'h400);
        step();
        chk("R7 rotate second", 64'(grant), 64'h004);
        release_all();
    endtask

    task automatic t_bad();
        req[4] = 1'b1; dst[4] = 4'd4;
        req[5] = 1'b1; dst[5] = 4'd13;
        step();
        chk("R8 err", 64'(err), 64'h030);
        chk("R8 no grant", 64'(grant), 0);
        chk("R8 no segs", 64'(busy), 0);
        release_all();
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = '0; dst = '0; done = '0;
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_cw_short();
        t_tie_and_ccw();
        t_blocked();
        t_capacity();
        t_round_robin();
        t_bad();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule